// File: doc/BRIEF.md
# Serial Register Bus Master with Background Fault Polling

This block drives a two-wire serial bus: a clock line, and a shared data line that either the master or the attached companion device can pull. It moves single 8-bit register values to and from that device. A local host asks for one read or one write at a time. It does this by raising a request with an address, a direction and, for a write, a data byte. The master returns a one-cycle completion pulse together with the read byte and an error indication.

When no host request is waiting, the master works through a fixed-size list of remote fault register addresses without any prompting, one frame per entry. Each value it reads back is stored in a local shadow register for that list slot, so fault state is always available locally. The serial clock comes from the system clock through a programmable divider. The clock toggles only while a frame is in progress and rests high between frames.

A frame has these parts in order: a start condition, 8 address bits, a direction bit, a dead slot, an acknowledge slot from the device, 8 data bits, a second dead slot, a second acknowledge slot, and a stop condition. The controller states are IDLE, START, ADDR, RW, DEAD1, ACK1, DATA, DEAD2, ACK2 and STOP. From IDLE the master always moves to START, loading either the host request or the next poll entry. Each bit state lasts one serial clock period: a low half, then a high half. At the end of each state the master moves to the next state in the list. There are two exceptions. ADDR and DATA repeat until all eight bits are sent or received. ACK1 jumps to STOP when the acknowledge is missing. STOP returns to IDLE.

Top module: `bsm_master`

## Requirements
- R1: While reset is held, the serial clock is high, the data line is released (`sda_oe`=0), `host_done`=0, `err_flag`=0 and all shadow registers are 0.
- R2: Every low half of the serial clock and every high half lasts `div_cfg`+1 system clocks. The serial clock changes only on a divider tick and rests high while the bus is idle.
- R3: In a write frame the master sends the address most significant bit first, then a direction bit of 1 (1 = write, 0 = read), then the data byte most significant bit first. The device receives exactly the host's address and byte.
- R4: A host read frame sends direction bit 0 and shifts in the device's byte most significant bit first. At the end of the frame, `host_rdata` holds that byte and `host_done` pulses high for exactly one cycle.
- R5: The master releases the data line in both dead slots, in both acknowledge slots, and in the data slots of a read frame.
- R6: An acknowledge slot that samples a high level aborts the frame: the master goes straight to STOP, `err_flag` becomes 1 and stays 1 until reset, and a host frame still completes with a `host_done` pulse.
- R7: Between host frames the master reads the addresses in `poll_addr` in rotating order (entry i in bits i*8+7..i*8). After each acknowledged poll it writes the result into `shadow_q` slot i. Shadow registers change at no other time.
- R8: A host request seen in IDLE always wins over polling. A poll frame already started is completed first, so a host request finishes within two frame lengths plus a few cycles.
- R9: Data driven by the master changes only while the serial clock is low. The only data-line changes during a high clock are the start condition (a fall) and the stop condition (a rise).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | DIVW | Serial clock half-period minus one, in system clocks |
| host_req | input | 1 | Host request, held until `host_done` |
| host_we | input | 1 | Request direction, 1 = write |
| host_addr | input | AW | Remote register address |
| host_wdata | input | DW | Byte to write |
| host_done | output | 1 | One-cycle completion pulse for a host frame |
| host_rdata | output | DW | Byte returned by the last host read |
| err_flag | output | 1 | Sticky missing-acknowledge flag |
| poll_addr | input | NPOLL*AW | Fault register address list |
| shadow_q | output | NPOLL*DW | Local copies of polled fault registers |
| scl | output | 1 | Serial clock |
| sda_o | output | 1 | Data value driven by the master |
| sda_oe | output | 1 | Master data drive enable |
| sda_i | input | 1 | Sampled level of the data line |

## Verification
A frame takes 46 half periods, each lasting `div_cfg`+1 cycles, plus one IDLE cycle. For host frames the bench therefore waits for the `host_done` pulse and bounds its latency against two frames, not against a fixed cycle count. The device model in the bench follows the wire itself. It samples the data line one half-cycle after every rising edge of the serial clock, and drives its acknowledge or read bit on the half-cycle after the falling edge. The master does not sample until the following divider tick, so every value is stable before it is read. Shadow contents are compared only after the bench has waited long enough for every poll slot to be refreshed. Clock-phase lengths are measured edge to edge, and the counters are restarted once a frame has passed after each divider change.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_ADDR,
        S_RW,
        S_DEAD1,
        S_ACK1,
        S_DATA,
        S_DEAD2,
        S_ACK2,
        S_STOP
    } bsm_state_t;
endpackage

// File: rtl/bsm_clkdiv.sv
module bsm_clkdiv #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= div;
        end else if (cnt == '0) begin
            cnt <= div;
        end else begin
            cnt <= cnt - DIVW'(1);
        end
    end

    assign tick = run && (cnt == '0);
endmodule

// File: rtl/bsm_shadow.sv
module bsm_shadow #(
    parameter int NPOLL = 4,
    parameter int DW    = 8,
    parameter int IDXW  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDXW-1:0]     wr_idx,
    input  logic [DW-1:0]       wr_data,
    output logic [NPOLL*DW-1:0] shadow_q
);
    genvar gi;
    generate
        for (gi = 0; gi < NPOLL; gi++) begin : g_slot
            logic [DW-1:0] val;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val <= '0;
                end else if (wr_en && wr_idx == IDXW'(gi)) begin
                    val <= wr_data;
                end
            end
            assign shadow_q[gi*DW +: DW] = val;
        end
    endgenerate
endmodule

// File: rtl/bsm_master.sv
module bsm_master
    import bsm_pkg::*;
#(
    parameter int DIVW  = 8,
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int NPOLL = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIVW-1:0]     div_cfg,
    input  logic                host_req,
    input  logic                host_we,
    input  logic [AW-1:0]       host_addr,
    input  logic [DW-1:0]       host_wdata,
    output logic                host_done,
    output logic [DW-1:0]       host_rdata,
    output logic                err_flag,
    input  logic [NPOLL*AW-1:0] poll_addr,
    output logic [NPOLL*DW-1:0] shadow_q,
    output logic                scl,
    output logic                sda_o,
    output logic                sda_oe,
    input  logic                sda_i
);
    localparam int MAXW = (AW > DW) ? AW : DW;
    localparam int CW   = $clog2(MAXW);
    localparam int IDXW = (NPOLL > 1) ? $clog2(NPOLL) : 1;

    bsm_state_t      st;
    logic            ph;
    logic [CW-1:0]   bitn;
    logic [AW-1:0]   tx_addr;
    logic [DW-1:0]   tx_data;
    logic [DW-1:0]   rx_sh;
    logic            cur_we;
    logic            cur_host;
    logic            nack;
    logic [IDXW-1:0] poll_idx;
    logic            err_q;
    logic            done_q;
    logic [DW-1:0]   rdata_q;
    logic            tick;
    logic            sh_we;
    logic            past_ok;

    bsm_clkdiv #(.DIVW(DIVW)) i_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (st != S_IDLE),
        .div  (div_cfg),
        .tick (tick)
    );

    assign sh_we = tick && ph && (st == S_STOP) && !cur_host && !nack;

    bsm_shadow #(.NPOLL(NPOLL), .DW(DW), .IDXW(IDXW)) i_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sh_we),
        .wr_idx  (poll_idx),
        .wr_data (rx_sh),
        .shadow_q(shadow_q)
    );

    // State register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            ph       <= 1'b0;
            bitn     <= '0;
            tx_addr  <= '0;
            tx_data  <= '0;
            rx_sh    <= '0;
            cur_we   <= 1'b0;
            cur_host <= 1'b0;
            nack     <= 1'b0;
            poll_idx <= '0;
            err_q    <= 1'b0;
            done_q   <= 1'b0;
            rdata_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (st == S_IDLE) begin
                ph   <= 1'b0;
                bitn <= '0;
                nack <= 1'b0;
                if (host_req) begin
                    tx_addr  <= host_addr;
                    tx_data  <= host_wdata;
                    cur_we   <= host_we;
                    cur_host <= 1'b1;
                end else begin
                    tx_addr  <= poll_addr[int'(poll_idx)*AW +: AW];
                    tx_data  <= '0;
                    cur_we   <= 1'b0;
                    cur_host <= 1'b0;
                end
                st <= S_START;
            end else if (tick) begin
                if (!ph) begin
                    // rising serial clock edge: sample the line
                    ph <= 1'b1;
                    if ((st == S_ACK1 || st == S_ACK2) && sda_i) nack <= 1'b1;
                    if (st == S_DATA && !cur_we) rx_sh <= {rx_sh[DW-2:0], sda_i};
                end else begin
                    // falling serial clock edge: advance the slot
                    ph <= 1'b0;
                    unique case (st)
                        S_START: begin
                            st   <= S_ADDR;
                            bitn <= '0;
                        end
                        S_ADDR: begin
                            tx_addr <= {tx_addr[AW-2:0], 1'b0};
                            if (bitn == CW'(AW-1)) st <= S_RW;
                            else bitn <= bitn + CW'(1);
                        end
                        S_RW:    st <= S_DEAD1;
                        S_DEAD1: st <= S_ACK1;
                        S_ACK1: begin
                            bitn <= '0;
                            st   <= nack ? S_STOP : S_DATA;
                        end
                        S_DATA: begin
                            tx_data <= {tx_data[DW-2:0], 1'b0};
                            if (bitn == CW'(DW-1)) st <= S_DEAD2;
                            else bitn <= bitn + CW'(1);
                        end
                        S_DEAD2: st <= S_ACK2;
                        S_ACK2:  st <= S_STOP;
                        S_STOP: begin
                            st    <= S_IDLE;
                            err_q <= err_q | nack;
                            if (cur_host) begin
                                done_q <= 1'b1;
                                if (!cur_we) rdata_q <= rx_sh;
                            end else if (poll_idx == IDXW'(NPOLL-1)) begin
                                poll_idx <= '0;
                            end else begin
                                poll_idx <= poll_idx + IDXW'(1);
                            end
                        end
                        default: st <= S_IDLE;
                    endcase
                end
            end
        end
    end

    // Bus outputs per state
    always_comb begin
        scl    = 1'b1;
        sda_o  = 1'b1;
        sda_oe = 1'b0;
        unique case (st)
            S_IDLE: begin
                scl = 1'b1;
            end
            S_START: begin
                scl    = 1'b1;
                sda_oe = 1'b1;
                sda_o  = !ph;
            end
            S_ADDR: begin
                scl    = ph;
                sda_oe = 1'b1;
                sda_o  = tx_addr[AW-1];
            end
            S_RW: begin
                scl    = ph;
                sda_oe = 1'b1;
                sda_o  = cur_we;
            end
            S_DEAD1, S_ACK1, S_DEAD2, S_ACK2: begin
                scl = ph;
            end
            S_DATA: begin
                scl    = ph;
                sda_oe = cur_we;
                sda_o  = tx_data[DW-1];
            end
            S_STOP: begin
                scl    = ph;
                sda_oe = 1'b1;
                sda_o  = 1'b0;
            end
            default: scl = 1'b1;
        endcase
    end

    assign host_done  = done_q;
    assign host_rdata = rdata_q;
    assign err_flag   = err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_scl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !tick |=> $stable(scl));

    p_sda_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && scl && $past(scl) && st == $past(st) &&
        (st == S_ADDR || st == S_RW || st == S_DATA)
        |-> $stable(sda_o) && $stable(sda_oe));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_host_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_IDLE && host_req |=> st == S_START && cur_host);

    p_shadow_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !$stable(shadow_q) |-> $past(st) == S_STOP && !$past(cur_host));
endmodule

// File: tb/test_bsm_master.sv
module test_bsm_master;
    localparam int CLK_PERIOD = 10;
    localparam int NPOLL = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       div_cfg = 8'd2;
    logic             host_req = 1'b0;
    logic             host_we = 1'b0;
    logic [7:0]       host_addr = '0;
    logic [7:0]       host_wdata = '0;
    logic             host_done;
    logic [7:0]       host_rdata;
    logic             err_flag;
    logic [NPOLL*8-1:0] poll_addr = {8'h13, 8'h12, 8'h11, 8'h10};
    logic [NPOLL*8-1:0] shadow_q;
    logic             scl, sda_o, sda_oe, sda_i;
    logic             slave_low = 1'b0;
    logic             sda_line;

    assign sda_line = sda_oe ? sda_o : !slave_low;
    assign sda_i    = sda_line;

    always #(CLK_PERIOD/2) clk = !clk;

    bsm_master #(.DIVW(8), .AW(8), .DW(8), .NPOLL(NPOLL)) i_bsm_master (
        .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_done(host_done), .host_rdata(host_rdata),
        .err_flag(err_flag), .poll_addr(poll_addr), .shadow_q(shadow_q),
        .scl(scl), .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_i)
    );

    int nvec = 0;
    int nbad = 0;
    bit finished = 1'b0;

    logic [7:0] smem [256];
    logic [7:0] emem [256];
    bit nack_mode = 1'b0;

    int hi_fall = 0, hi_rise = 0;
    int lo_n = 0, lo_bad = 0, lo_cnt = 0;
    int rel_n = 0, rel_bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int frame_len(input int d);
        return 46 * (d + 1) + 1;
    endfunction

    // Companion device model and wire monitor
    initial begin
        bit pscl = 1'b1, pline = 1'b1, srw = 1'b0;
        int k = 0;
        logic [7:0] saddr = '0, sdata = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (scl && pscl && (sda_line != pline)) begin
                    if (!sda_line) begin hi_fall++; k = 0; end
                    else hi_rise++;
                    slave_low = 1'b0;
                end else if (scl && !pscl) begin
                    k++;
                    lo_n++;
                    if (lo_cnt != int'(div_cfg) + 1) lo_bad++;
                    if (k == 10 || k == 11 || k == 20 || k == 21 || (!srw && k >= 12 && k <= 19)) begin
                        rel_n++;
                        if (sda_oe) rel_bad++;
                    end
                    if (k <= 8) saddr = {saddr[6:0], sda_line};
                    else if (k == 9) srw = sda_line;
                    else if (k >= 12 && k <= 19 && srw) begin
                        sdata = {sdata[6:0], sda_line};
                        if (k == 19) smem[saddr] = sdata;
                    end
                end else if (!scl && pscl) begin
                    lo_cnt = 0;
                    if (nack_mode) slave_low = 1'b0;
                    else if (k + 1 == 11 || k + 1 == 21) slave_low = 1'b1;
                    else if (!srw && k + 1 >= 12 && k + 1 <= 19) slave_low = !smem[saddr][19 - (k + 1)];
                    else slave_low = 1'b0;
                end
                if (!scl) lo_cnt++;
            end
            pscl  = scl;
            pline = sda_line;
        end
    end

    task automatic host_xfer(input bit we, input logic [7:0] a, input logic [7:0] d,
                             output logic [7:0] rd, output int lat);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!host_done && lat < 20000);
        rd = host_rdata;
        host_req = 1'b0;
    endtask

    task automatic settle_div(input logic [7:0] d);
        @(negedge clk);
        div_cfg = d;
        repeat (frame_len(d) * 2 + 600) @(negedge clk);
        lo_n = 0; lo_bad = 0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] rd; int lat;
        host_xfer(1'b1, a, d, rd, lat);
        emem[a] = d;
        chk(smem[a] == emem[a], "R3 write reaches device", smem[a], emem[a]);
        chk(lat >= 46 * (int'(div_cfg) + 1) && lat <= 2 * frame_len(int'(div_cfg)) + 4,
            "R8 host latency", lat, 2 * frame_len(int'(div_cfg)));
    endtask

    task automatic do_read(input logic [7:0] a);
        logic [7:0] rd; int lat;
        host_xfer(1'b0, a, 8'h00, rd, lat);
        chk(rd == emem[a], "R4 read data", rd, emem[a]);
        chk(lat <= 2 * frame_len(int'(div_cfg)) + 4, "R8 host latency", lat, 2 * frame_len(int'(div_cfg)));
    endtask

    task automatic check_shadows();
        repeat (frame_len(int'(div_cfg)) * (NPOLL + 2)) @(negedge clk);
        for (int i = 0; i < NPOLL; i++) begin
            logic [7:0] pa;
            pa = poll_addr[i*8 +: 8];
            chk(shadow_q[i*8 +: 8] == emem[pa], "R7 shadow matches device", shadow_q[i*8 +: 8], emem[pa]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nvec++; nbad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        int seed;
        int mode;
        logic [7:0] a, d;
        seed = $urandom(32'h5eed);
        for (int i = 0; i < 256; i++) begin
            smem[i] = 8'($urandom);
            emem[i] = smem[i];
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(scl == 1'b1, "R1 scl high in reset", scl, 1);
        chk(sda_oe == 1'b0, "R1 data released in reset", sda_oe, 0);
        chk(host_done == 1'b0 && err_flag == 1'b0, "R1 done/err clear", {host_done, err_flag}, 0);
        chk(shadow_q == '0, "R1 shadows zero", shadow_q, 0);
        rst_n = 1'b1;

        // directed corners at div 2
        settle_div(8'd2);
        do_write(8'hFF, 8'h00);
        do_write(8'h00, 8'hFF);
        do_read(8'hFF);
        do_read(8'h00);
        do_write(8'h11, 8'hA5);
        check_shadows();
        chk(lo_n > 0 && lo_bad == 0, "R2 low half equals div+1 (div 2)", lo_bad, 0);

        // random traffic at fastest divider
        settle_div(8'd0);
        for (int i = 0; i < 25; i++) begin
            mode = int'($urandom_range(0, 2));
            a = (mode == 0) ? 8'(8'h10 + $urandom_range(0, 3)) : 8'($urandom);
            d = 8'($urandom);
            if ($urandom_range(0, 1) == 1) do_write(a, d);
            else do_read(a);
        end
        check_shadows();
        chk(lo_n > 0 && lo_bad == 0, "R2 low half equals div+1 (div 0)", lo_bad, 0);

        // random traffic at a slow divider
        settle_div(8'd5);
        for (int i = 0; i < 10; i++) begin
            a = 8'($urandom);
            d = 8'($urandom);
            do_write(a, d);
            do_read(a);
        end
        do_write(8'h12, 8'h3C);
        check_shadows();
        chk(lo_n > 0 && lo_bad == 0, "R2 low half equals div+1 (div 5)", lo_bad, 0);
        chk(rel_n > 0 && rel_bad == 0, "R5 master releases device slots", rel_bad, 0);
        chk(hi_fall > 0 && (hi_fall - hi_rise == 0 || hi_fall - hi_rise == 1),
            "R9 only start/stop change data while clock high", hi_fall - hi_rise, 0);
        chk(err_flag == 1'b0, "R6 no error with acknowledges", err_flag, 0);

        // missing acknowledge
        begin
            logic [7:0] rd; int lat;
            @(negedge clk); nack_mode = 1'b1;
            host_xfer(1'b1, 8'h55, 8'h99, rd, lat);
            chk(lat < 20000, "R6 host frame completes on NACK", lat, 0);
            chk(err_flag == 1'b1, "R6 error flag set", err_flag, 1);
            chk(smem[8'h55] == emem[8'h55], "R6 aborted write leaves device unchanged", smem[8'h55], emem[8'h55]);
            @(negedge clk); nack_mode = 1'b0;
            repeat (frame_len(5) + 10) @(negedge clk);
            do_read(8'h55);
            chk(err_flag == 1'b1, "R6 error flag sticky", err_flag, 1);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule